// File: doc/BRIEF.md
# Inter-Processor Mailbox Controller

This block lets processor cores exchange short messages and interrupts through a set of shared mailboxes. Each core is tied to one channel, and each channel has its own interrupt output. A core takes a mailbox by writing its own channel bit into the mailbox owner register. It then picks the target channels and enables interrupt delivery for both sides. Next it places one 32-bit word in the payload register and raises the message interrupt through a two-bit send register.

The receiving core reads the payload. It may overwrite the payload with a reply, then flips the send register to raise the acknowledge interrupt back at the owner. The owner can send again on the same mailbox or release it. A release is a write of zero to the owner register, and it wipes all of that mailbox's state in one cycle.

Software reaches the block through a word-addressed read/write bus. Writes land on the clock edge. Reads are combinational and show the current register contents in the same cycle.

Top module: `ipc_mailbox_ctrl`

## Requirements
- R1: After reset every mailbox register, every status register and every interrupt output reads zero.
- R2: A write to a mailbox owner register stores the written channel bits only while that register reads zero. A nonzero write to an owned mailbox leaves the owner unchanged.
- R3: Writes to a mailbox's target, enable, send and payload registers are ignored while that mailbox has no owner.
- R4: The raw status word of channel c has bit m set exactly when mailbox m has send bit 0 set with c in its target register, or has send bit 1 set with c in its owner register.
- R5: The masked status word of channel c is its raw word ANDed, per mailbox, with enable bit c of that mailbox. Interrupt output c is high exactly when that masked word is nonzero.
- R6: Writing send value 2'b10 moves the interrupt from the target channels to the owner. Writing 2'b01 moves it back to the target channels.
- R7: The payload register holds a full 32-bit word that any channel's writes may replace while the mailbox is owned.
- R8: Writing zero to an owner register clears that mailbox's owner, target, enable, send and payload registers together, so its interrupts drop after that edge.
- R9: Mailbox m sits at word address 8*m, with offsets 0 owner, 1 target, 2 enable, 3 send, 4 payload. Channel c raw status is at 8*NUM_MB+2c and masked status at 8*NUM_MB+2c+1. Every other address reads zero and ignores writes, as do writes to the status words.
- R10: A write takes effect at the clock edge that samples it. Read data and interrupt outputs reflect the new state directly after that edge, with no further delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr_i | input | 1 | Write strobe for the current address |
| bus_addr_i | input | ADDR_W | Word address |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Combinational read data for bus_addr_i |
| irq_o | output | NUM_CH | One interrupt line per channel |

## Verification
Every result is due zero cycles after the clock edge that takes the write. Only one register stage lies between the bus and any output, and reads and interrupts are decoded combinationally from it. The bench therefore drives each write on a falling edge and holds it across one rising edge. It then reads status and interrupt lines on later falling edges, when the registered state has settled. The bench also keeps its own model of every register, built from the rules above. After each step of a claim, send, acknowledge, resend and release sequence, it compares every mailbox register, every status word and every interrupt line against that model. The sequence is swept over all mailbox, owner and target combinations.

// File: rtl/ipc_mbx_pkg.sv
package ipc_mbx_pkg;

    // Word offsets inside one mailbox window (window is 8 words)
    localparam int unsigned MBX_STRIDE_LOG2 = 3;

    typedef enum logic [2:0] {
        REG_OWNER  = 3'd0,
        REG_TARGET = 3'd1,
        REG_ENABLE = 3'd2,
        REG_SEND   = 3'd3,
        REG_DATA   = 3'd4
    } mbx_reg_e;

endpackage

// File: rtl/ipc_mbx_slot.sv
module ipc_mbx_slot
    import ipc_mbx_pkg::*;
#(
    parameter int unsigned NUM_CH = 4,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [2:0]        reg_sel_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [NUM_CH-1:0] owner_o,
    output logic [NUM_CH-1:0] target_o,
    output logic [NUM_CH-1:0] enable_o,
    output logic [1:0]        send_o,
    output logic [DATA_W-1:0] data_o,
    output logic [NUM_CH-1:0] raw_o
);

    typedef struct packed {
        logic [NUM_CH-1:0] owner;
        logic [NUM_CH-1:0] target;
        logic [NUM_CH-1:0] enable;
        logic [1:0]        send;
        logic [DATA_W-1:0] data;
    } slot_t;

    slot_t st_d, st_q;
    logic  owned;
    logic [NUM_CH-1:0] wr_ch;

    assign owned = |st_q.owner;
    assign wr_ch = wdata_i[NUM_CH-1:0];

    always_comb begin
        st_d = st_q;
        if (wr_en_i) begin
            case (reg_sel_i)
                REG_OWNER: begin
                    if (wr_ch == '0) begin
                        st_d = '0;                 // release wipes everything (R8)
                    end else if (!owned) begin
                        st_d.owner = wr_ch;        // claim only when free (R2)
                    end
                end
                REG_TARGET: if (owned) st_d.target = wr_ch;
                REG_ENABLE: if (owned) st_d.enable = wr_ch;
                REG_SEND:   if (owned) st_d.send   = wdata_i[1:0];
                REG_DATA:   if (owned) st_d.data   = wdata_i;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign owner_o  = st_q.owner;
    assign target_o = st_q.target;
    assign enable_o = st_q.enable;
    assign send_o   = st_q.send;
    assign data_o   = st_q.data;
    assign raw_o    = ({NUM_CH{st_q.send[0]}} & st_q.target)
                    | ({NUM_CH{st_q.send[1]}} & st_q.owner);

endmodule

// File: rtl/ipc_mbx_status.sv
module ipc_mbx_status #(
    parameter int unsigned NUM_CH = 4,
    parameter int unsigned NUM_MB = 4
) (
    input  logic [NUM_MB-1:0][NUM_CH-1:0] raw_i,
    input  logic [NUM_MB-1:0][NUM_CH-1:0] enable_i,
    output logic [NUM_CH-1:0][NUM_MB-1:0] raw_ch_o,
    output logic [NUM_CH-1:0][NUM_MB-1:0] masked_ch_o,
    output logic [NUM_CH-1:0]             irq_o
);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        for (genvar m = 0; m < NUM_MB; m++) begin : g_mb
            assign raw_ch_o[c][m]    = raw_i[m][c];
            assign masked_ch_o[c][m] = raw_i[m][c] & enable_i[m][c];
        end
        assign irq_o[c] = |masked_ch_o[c];
    end

endmodule

// File: rtl/ipc_mailbox_ctrl.sv
module ipc_mailbox_ctrl
    import ipc_mbx_pkg::*;
#(
    parameter int unsigned NUM_CH = 4,
    parameter int unsigned NUM_MB = 4,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic [NUM_CH-1:0] irq_o
);

    localparam int unsigned MB_SPAN   = NUM_MB << MBX_STRIDE_LOG2;
    localparam int unsigned STAT_BASE = MB_SPAN;
    localparam int unsigned STAT_END  = STAT_BASE + 2 * NUM_CH;
    localparam int unsigned IDX_W     = ADDR_W - MBX_STRIDE_LOG2;

    logic [NUM_MB-1:0][NUM_CH-1:0] owner_w, target_w, enable_w, raw_w;
    logic [NUM_MB-1:0][1:0]        send_w;
    logic [NUM_MB-1:0][DATA_W-1:0] data_w;
    logic [NUM_CH-1:0][NUM_MB-1:0] raw_ch_w, masked_ch_w;

    logic             in_mb;
    logic [IDX_W-1:0] mb_idx;
    logic [2:0]       reg_off;

    assign in_mb   = 32'(bus_addr_i) < MB_SPAN;
    assign mb_idx  = bus_addr_i[ADDR_W-1:MBX_STRIDE_LOG2];
    assign reg_off = bus_addr_i[MBX_STRIDE_LOG2-1:0];

    for (genvar m = 0; m < NUM_MB; m++) begin : g_slot
        logic slot_wr;
        assign slot_wr = bus_wr_i && in_mb && (mb_idx == IDX_W'(m));

        ipc_mbx_slot #(
            .NUM_CH (NUM_CH),
            .DATA_W (DATA_W)
        ) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en_i   (slot_wr),
            .reg_sel_i (reg_off),
            .wdata_i   (bus_wdata_i),
            .owner_o   (owner_w[m]),
            .target_o  (target_w[m]),
            .enable_o  (enable_w[m]),
            .send_o    (send_w[m]),
            .data_o    (data_w[m]),
            .raw_o     (raw_w[m])
        );
    end

    ipc_mbx_status #(
        .NUM_CH (NUM_CH),
        .NUM_MB (NUM_MB)
    ) u_status (
        .raw_i       (raw_w),
        .enable_i    (enable_w),
        .raw_ch_o    (raw_ch_w),
        .masked_ch_o (masked_ch_w),
        .irq_o       (irq_o)
    );

    always_comb begin
        logic [ADDR_W-1:0] stat_off;
        bus_rdata_o = '0;
        stat_off    = bus_addr_i - ADDR_W'(STAT_BASE);
        if (in_mb) begin
            for (int m = 0; m < NUM_MB; m++) begin
                if (mb_idx == IDX_W'(m)) begin
                    case (reg_off)
                        REG_OWNER:  bus_rdata_o = DATA_W'(owner_w[m]);
                        REG_TARGET: bus_rdata_o = DATA_W'(target_w[m]);
                        REG_ENABLE: bus_rdata_o = DATA_W'(enable_w[m]);
                        REG_SEND:   bus_rdata_o = DATA_W'(send_w[m]);
                        REG_DATA:   bus_rdata_o = data_w[m];
                        default:    bus_rdata_o = '0;
                    endcase
                end
            end
        end else if (32'(bus_addr_i) < STAT_END) begin
            for (int c = 0; c < NUM_CH; c++) begin
                if (stat_off[ADDR_W-1:1] == (ADDR_W-1)'(c)) begin
                    bus_rdata_o = stat_off[0] ? DATA_W'(masked_ch_w[c])
                                              : DATA_W'(raw_ch_w[c]);
                end
            end
        end
    end

endmodule

// File: rtl/ipc_mailbox_ctrl_chk.sv
module ipc_mailbox_ctrl_chk #(
    parameter int unsigned NUM_CH = 4,
    parameter int unsigned NUM_MB = 4,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 8
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          bus_wr_i,
    input logic [ADDR_W-1:0]             bus_addr_i,
    input logic [DATA_W-1:0]             bus_wdata_i,
    input logic [NUM_CH-1:0]             irq_o,
    input logic [NUM_MB-1:0][NUM_CH-1:0] owner_w,
    input logic [NUM_MB-1:0][NUM_CH-1:0] target_w,
    input logic [NUM_MB-1:0][NUM_CH-1:0] enable_w,
    input logic [NUM_MB-1:0][1:0]        send_w,
    input logic [NUM_MB-1:0][DATA_W-1:0] data_w
);

    for (genvar m = 0; m < NUM_MB; m++) begin : g_mb
        logic wr_owner, wr_send;
        assign wr_owner = bus_wr_i && (bus_addr_i == ADDR_W'(m * 8));
        assign wr_send  = bus_wr_i && (bus_addr_i == ADDR_W'(m * 8 + 3));

        assert_release_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_owner && bus_wdata_i[NUM_CH-1:0] == '0) |=>
            (owner_w[m] == '0 && target_w[m] == '0 && enable_w[m] == '0 &&
             send_w[m] == '0 && data_w[m] == '0));

        assert_claim_locked_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_owner && owner_w[m] != '0 && bus_wdata_i[NUM_CH-1:0] != '0) |=>
            $stable(owner_w[m]));

        assert_unowned_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (owner_w[m] == '0) |->
            (target_w[m] == '0 && enable_w[m] == '0 && send_w[m] == '0 && data_w[m] == '0));

        assert_ack_switch_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_send && owner_w[m] != '0 && bus_wdata_i[1:0] == 2'b10) |=>
            (send_w[m] == 2'b10));
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic has_source;
        always_comb begin
            has_source = 1'b0;
            for (int m = 0; m < NUM_MB; m++) begin
                if (enable_w[m][c] &&
                    ((send_w[m][0] && target_w[m][c]) || (send_w[m][1] && owner_w[m][c])))
                    has_source = 1'b1;
            end
        end

        assert_irq_has_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
            irq_o[c] |-> has_source);
    end

endmodule

bind ipc_mailbox_ctrl ipc_mailbox_ctrl_chk #(
    .NUM_CH (NUM_CH),
    .NUM_MB (NUM_MB),
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_wr_i    (bus_wr_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .irq_o       (irq_o),
    .owner_w     (owner_w),
    .target_w    (target_w),
    .enable_w    (enable_w),
    .send_w      (send_w),
    .data_w      (data_w)
);

// File: tb/ipc_mailbox_ctrl_bench.sv
`timescale 1ns/1ps
module ipc_mailbox_ctrl_bench;

    localparam int NCH = 4;
    localparam int NMB = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [3:0]  irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // bench-side model of every register
    logic [3:0]  m_own [NMB];
    logic [3:0]  m_tgt [NMB];
    logic [3:0]  m_en  [NMB];
    logic [1:0]  m_snd [NMB];
    logic [31:0] m_dat [NMB];

    always #2.5 clk = ~clk;

    ipc_mailbox_ctrl u_ipc_mailbox_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_wr_i    (wr),
        .bus_addr_i  (addr),
        .bus_wdata_i (wdata),
        .bus_rdata_o (rdata),
        .irq_o       (irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_write(input logic [7:0] a, input logic [31:0] d);
        int m;
        if (a < 8'(NMB * 8)) begin
            m = int'(a) / 8;
            case (a % 8)
                0: begin
                    if (d[3:0] == 4'h0) begin
                        m_own[m] = '0; m_tgt[m] = '0; m_en[m] = '0; m_snd[m] = '0; m_dat[m] = '0;
                    end else if (m_own[m] == 4'h0) begin
                        m_own[m] = d[3:0];
                    end
                end
                1: if (m_own[m] != 0) m_tgt[m] = d[3:0];
                2: if (m_own[m] != 0) m_en[m]  = d[3:0];
                3: if (m_own[m] != 0) m_snd[m] = d[1:0];
                4: if (m_own[m] != 0) m_dat[m] = d;
                default: ;
            endcase
        end
    endtask

    task automatic bwrite(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr = 1'b1; addr = a; wdata = d;
        @(posedge clk);
        model_write(a, d);
        #1 wr = 1'b0;
    endtask

    task automatic bread(input logic [7:0] a, output logic [31:0] v);
        @(negedge clk);
        wr = 1'b0; addr = a;
        #1 v = rdata;
    endtask

    task automatic check_all(input string tag);
        logic [31:0] v;
        logic [3:0]  raw_e, msk_e;
        for (int m = 0; m < NMB; m++) begin
            bread(8'(m * 8 + 0), v); chk({tag, " owner"}, v, 32'(m_own[m]));
            bread(8'(m * 8 + 1), v); chk({tag, " target"}, v, 32'(m_tgt[m]));
            bread(8'(m * 8 + 2), v); chk({tag, " enable"}, v, 32'(m_en[m]));
            bread(8'(m * 8 + 3), v); chk({tag, " send"}, v, 32'(m_snd[m]));
            bread(8'(m * 8 + 4), v); chk({tag, " R7 data"}, v, m_dat[m]);
        end
        for (int c = 0; c < NCH; c++) begin
            raw_e = '0;
            for (int m = 0; m < NMB; m++)
                raw_e[m] = (m_snd[m][0] & m_tgt[m][c]) | (m_snd[m][1] & m_own[m][c]);
            msk_e = '0;
            for (int m = 0; m < NMB; m++)
                msk_e[m] = raw_e[m] & m_en[m][c];
            bread(8'(NMB * 8 + 2 * c), v);     chk({tag, " R4 raw"}, v, 32'(raw_e));
            bread(8'(NMB * 8 + 2 * c + 1), v); chk({tag, " R5 masked"}, v, 32'(msk_e));
            chk({tag, " R5/R10 irq"}, 32'(irq[c]), 32'(msk_e != 0));
        end
    endtask

    initial begin
        logic [31:0] v;
        for (int m = 0; m < NMB; m++) begin
            m_own[m] = '0; m_tgt[m] = '0; m_en[m] = '0; m_snd[m] = '0; m_dat[m] = '0;
        end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        check_all("R1");

        for (int m = 0; m < NMB; m++) begin
            for (int s = 0; s < NCH; s++) begin
                for (int d = 0; d < NCH; d++) begin
                    if (d == s) continue;
                    // R3: writes before claim are dropped
                    bwrite(8'(m * 8 + 1), 32'(1 << d));
                    bwrite(8'(m * 8 + 4), 32'hDEAD_BEEF);
                    bread(8'(m * 8 + 1), v); chk("R3 target unowned", v, 32'h0);
                    bread(8'(m * 8 + 4), v); chk("R3 data unowned", v, 32'h0);
                    // R2: claim, then a rival claim is ignored
                    bwrite(8'(m * 8 + 0), 32'(1 << s));
                    bwrite(8'(m * 8 + 0), 32'(1 << d));
                    bread(8'(m * 8 + 0), v); chk("R2 owner locked", v, 32'(1 << s));
                    bwrite(8'(m * 8 + 2), ((m + s) % 2 == 1) ? 32'(1 << s)
                                                             : 32'((1 << s) | (1 << d)));
                    bwrite(8'(m * 8 + 1), 32'(1 << d));
                    bwrite(8'(m * 8 + 4), 32'hC0DE_0000 | 32'(m << 8) | 32'(s << 4) | 32'(d));
                    bwrite(8'(m * 8 + 3), 32'h1);
                    check_all("R4 message");
                    // receiver replies and acknowledges
                    bwrite(8'(m * 8 + 4), 32'h5A5A_0000 | 32'(m << 8) | 32'(s << 4) | 32'(d));
                    bwrite(8'(m * 8 + 3), 32'h2);
                    check_all("R6 ack");
                    bwrite(8'(m * 8 + 3), 32'h1);
                    check_all("R6 resend");
                    bwrite(8'(m * 8 + 0), 32'h0);
                    check_all("R8 release");
                end
            end
        end

        // R9: unused offsets, out-of-map addresses and status words ignore writes
        bwrite(8'd0, 32'h1);
        bwrite(8'd1, 32'h2);
        bwrite(8'd2, 32'h2);
        bwrite(8'd3, 32'h1);
        bwrite(8'd5, 32'hFFFF_FFFF);
        bread(8'd5, v); chk("R9 unused offset", v, 32'h0);
        bwrite(8'(NMB * 8 + 2 * NCH), 32'hFFFF_FFFF);
        bread(8'(NMB * 8 + 2 * NCH), v); chk("R9 beyond status", v, 32'h0);
        bwrite(8'(NMB * 8 + 2), 32'h0);
        bwrite(8'(NMB * 8 + 3), 32'h0);
        check_all("R9 status write ignored");
        bwrite(8'd0, 32'h0);
        check_all("R8 final release");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule